// File: doc/BRIEF.md
# I2C Double-Buffered Data Flag Controller

This block keeps the byte buffers and occupancy flags that sit behind the 8-bit data register of an I2C controller. The host sees one data location. A write fills a transmit buffer and a read returns a receive buffer. A single shift register sits between those buffers and the serial line, and three flags report where the data is. They are transmit-buffer-empty, shift-register-full and receive-buffer-full.

The serial engine does not pass waveforms to this block. It reports bus progress as one-cycle pulses: start seen, stop seen, falling edge of bit clock 1, falling edge of bit clock 8 and rising edge of bit clock 9. In receive mode it also presents the assembled byte. A mode input selects transmit or receive behaviour.

The host can reach the data location through two strobe pairs: a normal view and an alternate view. A view-select input decides which pair is live, and strobes on the other pair are ignored. The buffer contents after reset are not defined, and nothing relies on them.

Top module: `i2c_dbuf_flags`

## Requirements
- R1: After reset, `flag_tdre`, `flag_sdrf` and `flag_rdrf` are all 0.
- R2: When `alt_en` is 0, only `host_wr_std` and `host_rd_std` are honoured. When `alt_en` is 1, only `host_wr_alt` and `host_rd_alt` are honoured. A strobe on the inactive pair changes no flag and no buffer.
- R3: In transmit mode (`mode_tx` = 1), `ev_start` sets `flag_tdre` to 1 and clears `flag_sdrf`.
- R4: In transmit mode, an honoured host write stores `host_wdata` in the transmit buffer and clears `flag_tdre`, which marks the byte as pending.
- R5: In transmit mode, `ev_clk1_fall` with `flag_tdre` = 0 copies the transmit buffer to `shift_data` and sets both `flag_tdre` and `flag_sdrf`. With `flag_tdre` = 1 the pulse has no effect.
- R6: In either mode, `ev_stop` clears all three flags.
- R7: In receive mode, `ev_clk9_rise` loads `rx_byte` into the shift register. If `flag_rdrf` is 0, the byte is also copied to the receive buffer (`host_rdata`), `flag_rdrf` becomes 1 and `flag_sdrf` becomes 0. If `flag_rdrf` is 1, the receive buffer is kept and `flag_sdrf` becomes 1.
- R8: In receive mode, an honoured host read clears `flag_rdrf`. If `flag_sdrf` is then 1, the shift register moves to the receive buffer, `flag_rdrf` is set again and `flag_sdrf` is cleared.
- R9: When several inputs pulse in one cycle, they apply in this order: start, clock-1 fall, clock-9 rise, stop, then the host access. Each step sees the flags left by the step before it.
- R10: A cycle in which `mode_tx` differs from its registered value clears all three flags. Every event and host access in that cycle is ignored.
- R11: These inputs have no effect: `ev_clk8_fall` in both modes; `ev_start`, `ev_clk1_fall` and host writes in receive mode; `ev_clk9_rise` and host reads in transmit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_tx | input | 1 | 1 = transmit behaviour, 0 = receive behaviour |
| alt_en | input | 1 | Selects the alternate access view |
| host_wr_std | input | 1 | Write strobe, normal view |
| host_rd_std | input | 1 | Read strobe, normal view |
| host_wr_alt | input | 1 | Write strobe, alternate view |
| host_rd_alt | input | 1 | Read strobe, alternate view |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Receive buffer contents |
| ev_start | input | 1 | Start condition detected (pulse) |
| ev_stop | input | 1 | Stop condition detected (pulse) |
| ev_clk1_fall | input | 1 | Falling edge of bit clock 1 (pulse) |
| ev_clk8_fall | input | 1 | Falling edge of bit clock 8 (pulse) |
| ev_clk9_rise | input | 1 | Rising edge of bit clock 9 (pulse) |
| rx_byte | input | DATA_W | Byte assembled from the line, valid with `ev_clk9_rise` |
| shift_data | output | DATA_W | Shift register contents |
| flag_tdre | output | 1 | Transmit buffer empty |
| flag_sdrf | output | 1 | Shift register full |
| flag_rdrf | output | 1 | Receive buffer full |

## Verification
A bus event and a host access can fall in the same cycle. The key cases are a clock-9 rise arriving with a read while the receive buffer is full, and a clock-1 fall arriving with a write while a byte is pending. Directed sequences place these pairs, together with start-with-write and stop-with-read, in one cycle. The expected flags and buffers follow from the R9 ordering. A long pseudo-random sweep then pulses every event, strobe, view select and mode change freely. Each cycle is compared with a bench model that applies the requirements step by step.

// File: rtl/i2c_dbuf_pkg.sv
package i2c_dbuf_pkg;

    // Occupancy flags of the data path.
    typedef struct packed {
        logic tdre;   // transmit buffer empty
        logic sdrf;   // shift register full
        logic rdrf;   // receive buffer full
    } dbuf_flags_t;

    // Bus progress pulses, one cycle each.
    typedef struct packed {
        logic start;
        logic clk1_fall;
        logic clk8_fall;
        logic clk9_rise;
        logic stop;
    } dbuf_ev_t;

endpackage

// File: rtl/i2c_dbuf_access.sv
module i2c_dbuf_access (
    input  logic alt_en,
    input  logic wr_std,
    input  logic rd_std,
    input  logic wr_alt,
    input  logic rd_alt,
    output logic wr_ok,
    output logic rd_ok
);
    // Only the view chosen by alt_en reaches the data path.
    always_comb begin
        wr_ok = alt_en ? wr_alt : wr_std;
        rd_ok = alt_en ? rd_alt : rd_std;
    end
endmodule

// File: rtl/i2c_dbuf_tx_next.sv
module i2c_dbuf_tx_next
    import i2c_dbuf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  dbuf_flags_t       cur,
    input  dbuf_ev_t          ev,
    input  logic [DATA_W-1:0] tx_buf,
    input  logic [DATA_W-1:0] shift,
    input  logic              wr_ok,
    input  logic [DATA_W-1:0] wdata,
    output dbuf_flags_t       nxt,
    output logic [DATA_W-1:0] tx_buf_d,
    output logic [DATA_W-1:0] shift_d
);
    always_comb begin
        nxt      = cur;
        tx_buf_d = tx_buf;
        shift_d  = shift;
        // bus events first, in fixed order
        if (ev.start) begin
            nxt.tdre = 1'b1;
            nxt.sdrf = 1'b0;
        end
        if (ev.clk1_fall && !nxt.tdre) begin
            shift_d  = tx_buf;
            nxt.tdre = 1'b1;
            nxt.sdrf = 1'b1;
        end
        if (ev.stop) begin
            nxt = '0;
        end
        // host access last
        if (wr_ok) begin
            tx_buf_d = wdata;
            nxt.tdre = 1'b0;
        end
    end
endmodule

// File: rtl/i2c_dbuf_rx_next.sv
module i2c_dbuf_rx_next
    import i2c_dbuf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  dbuf_flags_t       cur,
    input  dbuf_ev_t          ev,
    input  logic [DATA_W-1:0] rx_buf,
    input  logic [DATA_W-1:0] shift,
    input  logic              rd_ok,
    input  logic [DATA_W-1:0] rx_byte,
    output dbuf_flags_t       nxt,
    output logic [DATA_W-1:0] rx_buf_d,
    output logic [DATA_W-1:0] shift_d
);
    always_comb begin
        nxt      = cur;
        rx_buf_d = rx_buf;
        shift_d  = shift;
        if (ev.clk9_rise) begin
            shift_d = rx_byte;
            if (!nxt.rdrf) begin
                rx_buf_d = rx_byte;
                nxt.rdrf = 1'b1;
                nxt.sdrf = 1'b0;
            end else begin
                nxt.sdrf = 1'b1;
            end
        end
        if (ev.stop) begin
            nxt = '0;
        end
        if (rd_ok) begin
            nxt.rdrf = 1'b0;
            if (nxt.sdrf) begin
                rx_buf_d = shift_d;
                nxt.rdrf = 1'b1;
                nxt.sdrf = 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_dbuf_flags.sv
module i2c_dbuf_flags
    import i2c_dbuf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_tx,
    input  logic              alt_en,
    input  logic              host_wr_std,
    input  logic              host_rd_std,
    input  logic              host_wr_alt,
    input  logic              host_rd_alt,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_clk1_fall,
    input  logic              ev_clk8_fall,
    input  logic              ev_clk9_rise,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [DATA_W-1:0] shift_data,
    output logic              flag_tdre,
    output logic              flag_sdrf,
    output logic              flag_rdrf
);
    localparam int unsigned BUF_W = DATA_W;

    typedef struct packed {
        logic              mode;
        dbuf_flags_t       flags;
        logic [BUF_W-1:0]  tx_buf;
        logic [BUF_W-1:0]  rx_buf;
        logic [BUF_W-1:0]  shift;
    } dbuf_state_t;

    dbuf_state_t st_q, st_d;
    dbuf_ev_t    ev;
    logic        wr_ok, rd_ok;

    dbuf_flags_t      tx_flags_d, rx_flags_d;
    logic [BUF_W-1:0] tx_buf_d, tx_shift_d, rx_buf_d, rx_shift_d;

    always_comb begin
        ev.start     = ev_start;
        ev.clk1_fall = ev_clk1_fall;
        ev.clk8_fall = ev_clk8_fall;
        ev.clk9_rise = ev_clk9_rise;
        ev.stop      = ev_stop;
    end

    i2c_dbuf_access access_i (
        .alt_en (alt_en),
        .wr_std (host_wr_std),
        .rd_std (host_rd_std),
        .wr_alt (host_wr_alt),
        .rd_alt (host_rd_alt),
        .wr_ok  (wr_ok),
        .rd_ok  (rd_ok)
    );

    i2c_dbuf_tx_next #(.DATA_W(BUF_W)) tx_i (
        .cur      (st_q.flags),
        .ev       (ev),
        .tx_buf   (st_q.tx_buf),
        .shift    (st_q.shift),
        .wr_ok    (wr_ok),
        .wdata    (host_wdata),
        .nxt      (tx_flags_d),
        .tx_buf_d (tx_buf_d),
        .shift_d  (tx_shift_d)
    );

    i2c_dbuf_rx_next #(.DATA_W(BUF_W)) rx_i (
        .cur      (st_q.flags),
        .ev       (ev),
        .rx_buf   (st_q.rx_buf),
        .shift    (st_q.shift),
        .rd_ok    (rd_ok),
        .rx_byte  (rx_byte),
        .nxt      (rx_flags_d),
        .rx_buf_d (rx_buf_d),
        .shift_d  (rx_shift_d)
    );

    // Next-state selection: a mode change wins over everything else.
    always_comb begin
        st_d = st_q;
        if (mode_tx != st_q.mode) begin
            st_d.mode  = mode_tx;
            st_d.flags = '0;
        end else if (st_q.mode) begin
            st_d.flags  = tx_flags_d;
            st_d.tx_buf = tx_buf_d;
            st_d.shift  = tx_shift_d;
        end else begin
            st_d.flags  = rx_flags_d;
            st_d.rx_buf = rx_buf_d;
            st_d.shift  = rx_shift_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = st_q.rx_buf;
    assign shift_data = st_q.shift;
    assign flag_tdre  = st_q.flags.tdre;
    assign flag_sdrf  = st_q.flags.sdrf;
    assign flag_rdrf  = st_q.flags.rdrf;
endmodule

// File: rtl/i2c_dbuf_chk.sv
module i2c_dbuf_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_tx,
    input logic              mode_q,
    input logic              alt_en,
    input logic              host_wr_std,
    input logic              host_rd_std,
    input logic              host_wr_alt,
    input logic              host_rd_alt,
    input logic              ev_start,
    input logic              ev_stop,
    input logic              ev_clk1_fall,
    input logic              ev_clk9_rise,
    input logic [DATA_W-1:0] tx_buf,
    input logic [DATA_W-1:0] host_rdata,
    input logic [DATA_W-1:0] shift_data,
    input logic              flag_tdre,
    input logic              flag_sdrf,
    input logic              flag_rdrf
);
    logic wr_live, rd_live, steady;
    assign wr_live = alt_en ? host_wr_alt : host_wr_std;
    assign rd_live = alt_en ? host_rd_alt : host_rd_std;
    assign steady  = (mode_tx == mode_q);

    a_r10_mode_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !steady |=> (!flag_tdre && !flag_sdrf && !flag_rdrf));

    a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && ev_stop) |=> (!flag_tdre && !flag_sdrf && !flag_rdrf));

    a_r3_start_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && mode_q && ev_start && !ev_stop && !wr_live) |=> (flag_tdre && !flag_sdrf));

    a_r4_write_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && mode_q && wr_live) |=> !flag_tdre);

    a_r5_load_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && mode_q && ev_clk1_fall && !ev_start && !flag_tdre && !ev_stop && !wr_live)
        |=> (flag_tdre && flag_sdrf && shift_data == $past(tx_buf)));

    a_r7_held_implies_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && flag_sdrf) |-> flag_rdrf);

    a_r8_read_moves_held: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && !mode_q && rd_live && flag_sdrf && !ev_stop && !ev_clk9_rise)
        |=> (flag_rdrf && !flag_sdrf && host_rdata == $past(shift_data)));
endmodule

bind i2c_dbuf_flags i2c_dbuf_chk #(.DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_tx      (mode_tx),
    .mode_q       (st_q.mode),
    .alt_en       (alt_en),
    .host_wr_std  (host_wr_std),
    .host_rd_std  (host_rd_std),
    .host_wr_alt  (host_wr_alt),
    .host_rd_alt  (host_rd_alt),
    .ev_start     (ev_start),
    .ev_stop      (ev_stop),
    .ev_clk1_fall (ev_clk1_fall),
    .ev_clk9_rise (ev_clk9_rise),
    .tx_buf       (st_q.tx_buf),
    .host_rdata   (host_rdata),
    .shift_data   (shift_data),
    .flag_tdre    (flag_tdre),
    .flag_sdrf    (flag_sdrf),
    .flag_rdrf    (flag_rdrf)
);

// File: tb/i2c_dbuf_flags_tb_top.sv
module i2c_dbuf_flags_tb_top;
    localparam int unsigned W = 8;
    localparam logic [4:0] E_NONE  = 5'b00000;
    localparam logic [4:0] E_START = 5'b00001;
    localparam logic [4:0] E_CLK1  = 5'b00010;
    localparam logic [4:0] E_CLK8  = 5'b00100;
    localparam logic [4:0] E_CLK9  = 5'b01000;
    localparam logic [4:0] E_STOP  = 5'b10000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_tx = 1'b0, alt_en = 1'b0;
    logic host_wr_std = 1'b0, host_rd_std = 1'b0, host_wr_alt = 1'b0, host_rd_alt = 1'b0;
    logic [W-1:0] host_wdata = '0, rx_byte = '0;
    logic ev_start = 1'b0, ev_stop = 1'b0, ev_clk1_fall = 1'b0, ev_clk8_fall = 1'b0, ev_clk9_rise = 1'b0;
    logic [W-1:0] host_rdata, shift_data;
    logic flag_tdre, flag_sdrf, flag_rdrf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    logic m_mode = 1'b0, m_tdre = 1'b0, m_sdrf = 1'b0, m_rdrf = 1'b0;
    logic [W-1:0] m_tx = '0, m_rx = '0, m_sh = '0;
    bit k_tx = 1'b0, k_rx = 1'b0, k_sh = 1'b0;

    always #5 clk = ~clk;

    i2c_dbuf_flags #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_tx(mode_tx), .alt_en(alt_en),
        .host_wr_std(host_wr_std), .host_rd_std(host_rd_std),
        .host_wr_alt(host_wr_alt), .host_rd_alt(host_rd_alt),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_clk1_fall(ev_clk1_fall),
        .ev_clk8_fall(ev_clk8_fall), .ev_clk9_rise(ev_clk9_rise),
        .rx_byte(rx_byte), .shift_data(shift_data),
        .flag_tdre(flag_tdre), .flag_sdrf(flag_sdrf), .flag_rdrf(flag_rdrf)
    );

    task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected next state, applied step by step from the requirements.
    task automatic model_step(input logic [4:0] e, input logic ws, rs, wa, ra,
                              input logic [W-1:0] wd, rb);
        logic w, r;
        w = alt_en ? wa : ws;
        r = alt_en ? ra : rs;
        if (mode_tx != m_mode) begin
            m_mode = mode_tx;
            {m_tdre, m_sdrf, m_rdrf} = 3'b000;
            return;
        end
        if (m_mode) begin
            if (e[0]) begin m_tdre = 1'b1; m_sdrf = 1'b0; end
            if (e[1] && !m_tdre) begin
                m_sh = m_tx; k_sh = k_tx; m_tdre = 1'b1; m_sdrf = 1'b1;
            end
            if (e[4]) {m_tdre, m_sdrf, m_rdrf} = 3'b000;
            if (w) begin m_tx = wd; k_tx = 1'b1; m_tdre = 1'b0; end
        end else begin
            if (e[3]) begin
                m_sh = rb; k_sh = 1'b1;
                if (!m_rdrf) begin m_rx = rb; k_rx = 1'b1; m_rdrf = 1'b1; m_sdrf = 1'b0; end
                else m_sdrf = 1'b1;
            end
            if (e[4]) {m_tdre, m_sdrf, m_rdrf} = 3'b000;
            if (r) begin
                m_rdrf = 1'b0;
                if (m_sdrf) begin m_rx = m_sh; k_rx = k_sh; m_rdrf = 1'b1; m_sdrf = 1'b0; end
            end
        end
    endtask

    // One cycle: drive at the falling edge, compare at the next falling edge.
    task automatic cyc(input logic [4:0] e, input logic ws, rs, wa, ra,
                       input logic [W-1:0] wd, rb, input string tag);
        {ev_stop, ev_clk9_rise, ev_clk8_fall, ev_clk1_fall, ev_start} = e;
        {host_wr_std, host_rd_std, host_wr_alt, host_rd_alt} = {ws, rs, wa, ra};
        host_wdata = wd;
        rx_byte = rb;
        model_step(e, ws, rs, wa, ra, wd, rb);
        @(negedge clk);
        {ev_stop, ev_clk9_rise, ev_clk8_fall, ev_clk1_fall, ev_start} = E_NONE;
        {host_wr_std, host_rd_std, host_wr_alt, host_rd_alt} = 4'b0000;
        chk(tag, "tdre", {7'd0, flag_tdre}, {7'd0, m_tdre});
        chk(tag, "sdrf", {7'd0, flag_sdrf}, {7'd0, m_sdrf});
        chk(tag, "rdrf", {7'd0, flag_rdrf}, {7'd0, m_rdrf});
        if (k_sh) chk(tag, "shift", shift_data, m_sh);
        if (k_rx) chk(tag, "rxbuf", host_rdata, m_rx);
    endtask

    task automatic ev(input logic [4:0] e, input string tag);
        cyc(e, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "flags", {5'd0, flag_tdre, flag_sdrf, flag_rdrf}, 8'h00);

        // R10 enter transmit mode, start in the same cycle is ignored
        mode_tx = 1'b1;
        ev(E_START, "R10");
        chk("R10", "tdre after ignored start", {7'd0, flag_tdre}, 8'h00);

        // transmit sequence
        ev(E_START, "R3");
        chk("R3", "tdre", {7'd0, flag_tdre}, 8'h01);
        cyc(E_NONE, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, '0, "R4");
        chk("R4", "tdre", {7'd0, flag_tdre}, 8'h00);
        ev(E_CLK1, "R5");
        chk("R5", "shift", shift_data, 8'hA5);
        chk("R5", "sdrf", {7'd0, flag_sdrf}, 8'h01);
        ev(E_CLK8, "R11");
        ev(E_CLK9, "R11");
        cyc(E_NONE, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, "R11");
        cyc(E_NONE, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, '0, "R4");
        ev(E_CLK1, "R5");
        chk("R5", "second byte", shift_data, 8'h3C);
        ev(E_CLK1, "R5");
        ev(E_STOP, "R6");
        chk("R6", "flags", {5'd0, flag_tdre, flag_sdrf, flag_rdrf}, 8'h00);

        // R2 alternate view
        alt_en = 1'b1;
        ev(E_START, "R2");
        cyc(E_NONE, 1'b1, 1'b0, 1'b0, 1'b0, 8'h11, '0, "R2");
        chk("R2", "std write ignored", {7'd0, flag_tdre}, 8'h01);
        cyc(E_NONE, 1'b0, 1'b0, 1'b1, 1'b0, 8'h77, '0, "R2");
        ev(E_CLK1, "R2");
        chk("R2", "alt write shifted", shift_data, 8'h77);
        alt_en = 1'b0;
        ev(E_START, "R2");
        cyc(E_NONE, 1'b0, 1'b0, 1'b1, 1'b0, 8'h22, '0, "R2");
        chk("R2", "alt write ignored", {7'd0, flag_tdre}, 8'h01);

        // R9 same-cycle ordering, transmit
        cyc(E_START, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5E, '0, "R9");
        chk("R9", "start+write tdre", {7'd0, flag_tdre}, 8'h00);
        cyc(E_CLK1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hE7, '0, "R9");
        chk("R9", "clk1+write shift", shift_data, 8'h5E);
        chk("R9", "clk1+write tdre", {7'd0, flag_tdre}, 8'h00);
        cyc(E_STOP, 1'b1, 1'b0, 1'b0, 1'b0, 8'h90, '0, "R9");

        // receive mode
        mode_tx = 1'b0;
        ev(E_NONE, "R10");
        chk("R10", "flags", {5'd0, flag_tdre, flag_sdrf, flag_rdrf}, 8'h00);
        cyc(E_CLK9, 1'b0, 1'b0, 1'b0, 1'b0, '0, 8'h5A, "R7");
        chk("R7", "rxbuf", host_rdata, 8'h5A);
        cyc(E_CLK9, 1'b0, 1'b0, 1'b0, 1'b0, '0, 8'hC3, "R7");
        chk("R7", "held", {6'd0, flag_sdrf, flag_rdrf}, 8'h03);
        chk("R7", "rxbuf kept", host_rdata, 8'h5A);
        cyc(E_NONE, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, "R8");
        chk("R8", "moved", host_rdata, 8'hC3);
        cyc(E_NONE, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, "R8");
        chk("R8", "rdrf", {7'd0, flag_rdrf}, 8'h00);
        cyc(E_CLK9, 1'b0, 1'b0, 1'b0, 1'b0, '0, 8'h41, "R7");
        cyc(E_CLK9, 1'b0, 1'b1, 1'b0, 1'b0, '0, 8'h82, "R9");
        chk("R9", "clk9+read rxbuf", host_rdata, 8'h82);
        ev(E_START | E_CLK1 | E_CLK8, "R11");
        cyc(E_NONE, 1'b1, 1'b0, 1'b0, 1'b0, 8'hEE, '0, "R11");
        cyc(E_CLK9, 1'b0, 1'b1, 1'b0, 1'b0, '0, 8'h19, "R9");
        cyc(E_STOP, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, "R6");
        chk("R6", "rx flags", {5'd0, flag_tdre, flag_sdrf, flag_rdrf}, 8'h00);

        // R11: the receive-mode write must not reach the transmit buffer
        mode_tx = 1'b1;
        ev(E_NONE, "R10");
        ev(E_CLK1, "R11");
        chk("R11", "tx buffer unchanged", shift_data, 8'h90);

        // pseudo-random sweep against the model
        lf = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[15:11] == 5'd3) mode_tx = ~mode_tx;
            if (lf[15:11] == 5'd7) alt_en = ~alt_en;
            cyc(lf[4:0] & lf[9:5] & lf[14:10],
                lf[1] & lf[6], lf[2] & lf[8], lf[3] & lf[11], lf[0] & lf[12],
                lf[7:0] ^ 8'(i), lf[15:8], "R9");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule